// File: doc/BRIEF.md
# Audio Frame Channel Mask Serializer

This block holds the slot logic for one serial data line of a frame-based audio port. It runs on the bit clock. A rising edge on the frame-sync input starts a frame, and the frame is then split into fixed-width word slots. In single-phase (TDM) mode a frame has eight slots. In dual-phase mode it has two slots, left and right. An eight-bit channel mask chooses which slots carry audio. For each enabled slot the block takes one word from a transmit FIFO and shifts it out MSB first. It also collects the bits arriving on the input line and writes the finished word to a receive FIFO. Disabled slots are never fetched and never stored.

Dual-phase mode has a mono option. With only mask bit 0 set, the left word is sent again in the right phase and only the left word is stored on receive. An all-zero mask keeps the output line at zero and stores nothing. Word length is set by the configuration from 8 to 24 bits. The slot width is a parameter that must be larger than the widest word. Mode, mask and word length are latched at the start of each frame. FIFO underflow and overflow are recorded in flags that stay set until reset.

Top module: `aud_slot_serializer`

## Requirements
- R1: While reset is asserted and just after it is released, with no frame-sync edge seen, `sd_out`, `tx_pop`, `rx_push`, `tx_underrun` and `rx_overrun` are all 0.
- R2: A frame starts in the cycle where `fsync` is sampled high after being low in the previous cycle. Bit j of slot k is on `sd_out` in the cycle that is 1 + k*SLOT_W + j cycles after that start cycle. The word is the low `cfg_wlen` bits of `tx_data`, sent most significant bit first.
- R3: In single-phase mode (`cfg_dual`=0) a frame has 8 slots, and mask bit k enables slot k. The word for an enabled slot is fetched with `tx_pop` high for one cycle. For slot 0 this is the start cycle. For slot k>0 it is the last bit cycle of slot k-1, which is k*SLOT_W cycles after the start.
- R4: For a slot whose mask bit is 0, `sd_out` stays 0 for the whole slot, and no `tx_pop` or `rx_push` is issued for it.
- R5: In a slot, the bit positions at or after the word length are driven as 0, and the bits received there are ignored. An enabled slot is written with `rx_push` in its last bit cycle. `rx_data` then holds the first `cfg_wlen` received bits right-aligned, with the first bit as MSB and the upper bits 0.
- R6: In dual-phase mode (`cfg_dual`=1) a frame has 2 slots and mask bits 7:2 are ignored. With mask bits 1:0 = 11 each phase carries its own fetched and stored word.
- R7: In dual-phase mode with mask bits 1:0 = 01, slot 1 sends the same word as slot 0 without a fetch, and nothing is stored for slot 1.
- R8: When the effective mask is zero (all 8 bits in single-phase mode, bits 1:0 in dual-phase mode), `sd_out` is 0 for the whole frame and neither `tx_pop` nor `rx_push` occurs.
- R9: If an enabled slot needs a word while `tx_empty` is 1, no pop is issued, the slot is sent as zeros, and `tx_underrun` goes to 1 and stays 1 until reset.
- R10: If an enabled slot ends while `rx_full` is 1, no push is issued and `rx_overrun` goes to 1 and stays 1 until reset.
- R11: A frame-sync edge that arrives before the frame is complete restarts the frame at slot 0. The slot that was interrupted is not stored.
- R12: Changes on `cfg_dual`, `cfg_mask` and `cfg_wlen` after the start cycle have no effect until the next frame start.
- R13: Once all slots of a frame have been sent, `sd_out` stays 0 and no pop or push occurs until the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fsync | input | 1 | Frame sync; a rising edge starts a frame |
| cfg_dual | input | 1 | 1 = dual-phase (two slots), 0 = single-phase (eight slots) |
| cfg_mask | input | 8 | Slot enable mask; bit k enables slot k |
| cfg_wlen | input | LEN_W (5) | Word length in bits, 8 to 24 |
| tx_empty | input | 1 | Transmit FIFO has no word |
| tx_data | input | WORD_W (24) | Head word of the transmit FIFO (show-ahead) |
| tx_pop | output | 1 | Consume the head word of the transmit FIFO |
| rx_full | input | 1 | Receive FIFO cannot accept a word |
| rx_push | output | 1 | Write `rx_data` into the receive FIFO |
| rx_data | output | WORD_W (24) | Received word, right-aligned |
| sd_in | input | 1 | Serial data in |
| sd_out | output | 1 | Serial data out |
| tx_underrun | output | 1 | Sticky: a word was needed while the transmit FIFO was empty |
| rx_overrun | output | 1 | Sticky: a word was dropped because the receive FIFO was full |

## Verification
The assertions assume that `cfg_wlen` lies between 8 and 24 when a frame starts, that the transmit FIFO is show-ahead so `tx_data` is valid in the same cycle as `tx_pop`, and that `fsync` has a low cycle between any two frame starts. The stimulus sets the configuration once per frame from values inside those ranges. It drives `fsync` as a one-cycle pulse, so consecutive starts are always separated by low cycles. It also scrambles the configuration inputs freely in the middle of each frame. The FIFO model in the bench presents the head word combinationally and moves its read pointer only after a pop it has seen. Fill levels and the receive full flag are drawn at random so that the underrun and overrun paths get exercised.

// File: rtl/aud_slot_pkg.sv
package aud_slot_pkg;

    localparam int MAX_SLOTS    = 8;
    localparam int SLOT_IDX_W   = $clog2(MAX_SLOTS);
    localparam int STEREO_SLOTS = 2;

    typedef logic [MAX_SLOTS-1:0]  slot_mask_t;
    typedef logic [SLOT_IDX_W-1:0] slot_idx_t;

    // number of word slots in one frame for the selected phase mode
    function automatic int unsigned frame_slots(logic dual);
        return dual ? STEREO_SLOTS : MAX_SLOTS;
    endfunction

    // a slot carries its own fetched/stored word
    function automatic logic slot_active(slot_mask_t m, logic dual, slot_idx_t k);
        if (dual && (int'(k) >= STEREO_SLOTS)) begin
            return 1'b0;
        end
        return m[k];
    endfunction

    // mono in dual-phase: second phase repeats the first word
    function automatic logic slot_repeat(slot_mask_t m, logic dual, slot_idx_t k);
        return dual && (k == slot_idx_t'(1)) && (m[1:0] == 2'b01);
    endfunction

endpackage

// File: rtl/aud_slot_sequencer.sv
module aud_slot_sequencer
    import aud_slot_pkg::*;
#(
    parameter  int SLOT_W   = 32,
    parameter  int WORD_W   = 24,
    parameter  int MIN_WLEN = 8,
    localparam int LEN_W    = $clog2(WORD_W + 1),
    localparam int BIT_W    = $clog2(SLOT_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync,
    input  logic             cfg_dual,
    input  slot_mask_t       cfg_mask,
    input  logic [LEN_W-1:0] cfg_wlen,
    output logic             frame_start,
    output logic             load_en,
    output logic             load_active,
    output logic             load_repeat,
    output logic [LEN_W-1:0] load_wlen,
    output logic             slot_end,
    output logic             end_active,
    output logic             in_frame,
    output logic [BIT_W-1:0] bit_idx,
    output slot_mask_t       cur_mask,
    output logic             cur_dual,
    output logic [LEN_W-1:0] cur_wlen
);

    typedef struct packed {
        logic             fs;
        logic             in_frame;
        slot_idx_t        slot;
        logic [BIT_W-1:0] bitc;
        slot_mask_t       mask;
        logic             dual;
        logic [LEN_W-1:0] wlen;
    } seq_state_t;

    localparam seq_state_t SEQ_RESET = '{
        fs:       1'b0,
        in_frame: 1'b0,
        slot:     '0,
        bitc:     '0,
        mask:     slot_mask_t'(8'h03),
        dual:     1'b0,
        wlen:     LEN_W'(WORD_W)
    };

    seq_state_t seq_d, seq_q;
    logic       last_slot;
    slot_idx_t  next_slot;

    function automatic logic [LEN_W-1:0] clamp_len(logic [LEN_W-1:0] w);
        if (int'(w) < MIN_WLEN) begin
            return LEN_W'(MIN_WLEN);
        end
        if (int'(w) > WORD_W) begin
            return LEN_W'(WORD_W);
        end
        return w;
    endfunction

    always_comb begin
        seq_d       = seq_q;
        seq_d.fs    = fsync;
        frame_start = fsync & ~seq_q.fs;
        slot_end    = seq_q.in_frame & (seq_q.bitc == BIT_W'(SLOT_W - 1));
        last_slot   = (seq_q.slot == slot_idx_t'(frame_slots(seq_q.dual) - 1));
        next_slot   = seq_q.slot + slot_idx_t'(1);
        end_active  = slot_end & ~frame_start
                    & slot_active(seq_q.mask, seq_q.dual, seq_q.slot);
        load_en     = frame_start | slot_end;
        load_active = 1'b0;
        load_repeat = 1'b0;
        load_wlen   = seq_q.wlen;

        if (frame_start) begin
            // a new frame restarts even when the previous one is unfinished
            seq_d.in_frame = 1'b1;
            seq_d.slot     = '0;
            seq_d.bitc     = '0;
            seq_d.mask     = cfg_mask;
            seq_d.dual     = cfg_dual;
            seq_d.wlen     = clamp_len(cfg_wlen);
            load_active    = slot_active(cfg_mask, cfg_dual, '0);
            load_repeat    = 1'b0;
            load_wlen      = clamp_len(cfg_wlen);
        end else if (seq_q.in_frame) begin
            seq_d.bitc = seq_q.bitc + BIT_W'(1);
            if (slot_end) begin
                seq_d.bitc = '0;
                if (last_slot) begin
                    seq_d.in_frame = 1'b0;
                end else begin
                    seq_d.slot  = next_slot;
                    load_active = slot_active(seq_q.mask, seq_q.dual, next_slot);
                    load_repeat = slot_repeat(seq_q.mask, seq_q.dual, next_slot);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= SEQ_RESET;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign in_frame = seq_q.in_frame;
    assign bit_idx  = seq_q.bitc;
    assign cur_mask = seq_q.mask;
    assign cur_dual = seq_q.dual;
    assign cur_wlen = seq_q.wlen;

    AST_CFG_FROZEN_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.in_frame && !frame_start) |=> ($stable(cur_mask) && $stable(cur_dual) && $stable(cur_wlen))); // R12

    AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.in_frame |-> (int'(seq_q.slot) < int'(frame_slots(seq_q.dual)))); // R6

endmodule

// File: rtl/aud_slot_tx.sv
module aud_slot_tx #(
    parameter  int WORD_W = 24,
    localparam int LEN_W  = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic              load_active,
    input  logic              load_repeat,
    input  logic [LEN_W-1:0]  load_wlen,
    input  logic              tx_empty,
    input  logic [WORD_W-1:0] tx_data,
    output logic              tx_pop,
    output logic              underrun,
    output logic              sd_out
);

    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [WORD_W-1:0] hold;
        logic              under;
    } tx_state_t;

    tx_state_t         tx_d, tx_q;
    logic [WORD_W-1:0] aligned;

    always_comb begin
        tx_d    = tx_q;
        tx_d.sh = tx_q.sh << 1;
        // move the word's top bit to the shifter MSB; bits above wlen fall off
        aligned = tx_data << (LEN_W'(WORD_W) - load_wlen);
        tx_pop  = load_en & load_active & ~load_repeat & ~tx_empty;

        if (load_en) begin
            if (load_repeat) begin
                tx_d.sh = tx_q.hold;
            end else if (load_active) begin
                if (tx_empty) begin
                    tx_d.sh    = '0;
                    tx_d.hold  = '0;
                    tx_d.under = 1'b1;
                end else begin
                    tx_d.sh   = aligned;
                    tx_d.hold = aligned;
                end
            end else begin
                tx_d.sh = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else begin
            tx_q <= tx_d;
        end
    end

    assign sd_out   = tx_q.sh[WORD_W-1];
    assign underrun = tx_q.under;

    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_q.under |=> tx_q.under); // R9

endmodule

// File: rtl/aud_slot_rx.sv
module aud_slot_rx #(
    parameter  int WORD_W = 24,
    parameter  int BIT_W  = 5,
    localparam int LEN_W  = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sd_in,
    input  logic              in_frame,
    input  logic              frame_start,
    input  logic [BIT_W-1:0]  bit_idx,
    input  logic [LEN_W-1:0]  wlen,
    input  logic              slot_end,
    input  logic              end_active,
    input  logic              rx_full,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_data,
    output logic              overrun
);

    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic              over;
    } rx_state_t;

    rx_state_t rx_d, rx_q;

    always_comb begin
        rx_d    = rx_q;
        rx_data = rx_q.sh;
        if (in_frame && (int'(bit_idx) < int'(wlen))) begin
            rx_data = {rx_q.sh[WORD_W-2:0], sd_in};
        end
        rx_d.sh = rx_data;
        if (frame_start || !in_frame || slot_end) begin
            rx_d.sh = '0;
        end
        rx_push = end_active & ~rx_full;
        if (end_active && rx_full) begin
            rx_d.over = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign overrun = rx_q.over;

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_q.over |=> rx_q.over); // R10

    AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && slot_end) |=> (overrun || !$past(end_active))); // R10

endmodule

// File: rtl/aud_slot_serializer.sv
module aud_slot_serializer
    import aud_slot_pkg::*;
#(
    parameter  int SLOT_W   = 32,
    parameter  int WORD_W   = 24,
    parameter  int MIN_WLEN = 8,
    localparam int LEN_W    = $clog2(WORD_W + 1),
    localparam int BIT_W    = $clog2(SLOT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync,
    input  logic              cfg_dual,
    input  logic [7:0]        cfg_mask,
    input  logic [LEN_W-1:0]  cfg_wlen,
    input  logic              tx_empty,
    input  logic [WORD_W-1:0] tx_data,
    output logic              tx_pop,
    input  logic              rx_full,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_data,
    input  logic              sd_in,
    output logic              sd_out,
    output logic              tx_underrun,
    output logic              rx_overrun
);

    // slot must leave at least one bit past the longest word
    if (SLOT_W <= WORD_W) begin : g_bad_slot_width
        $error("SLOT_W must exceed WORD_W");
    end

    logic             frame_start;
    logic             load_en;
    logic             load_active;
    logic             load_repeat;
    logic [LEN_W-1:0] load_wlen;
    logic             slot_end;
    logic             end_active;
    logic             in_frame;
    logic [BIT_W-1:0] bit_idx;
    slot_mask_t       cur_mask;
    logic             cur_dual;
    logic [LEN_W-1:0] cur_wlen;

    aud_slot_sequencer #(
        .SLOT_W   (SLOT_W),
        .WORD_W   (WORD_W),
        .MIN_WLEN (MIN_WLEN)
    ) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .fsync       (fsync),
        .cfg_dual    (cfg_dual),
        .cfg_mask    (cfg_mask),
        .cfg_wlen    (cfg_wlen),
        .frame_start (frame_start),
        .load_en     (load_en),
        .load_active (load_active),
        .load_repeat (load_repeat),
        .load_wlen   (load_wlen),
        .slot_end    (slot_end),
        .end_active  (end_active),
        .in_frame    (in_frame),
        .bit_idx     (bit_idx),
        .cur_mask    (cur_mask),
        .cur_dual    (cur_dual),
        .cur_wlen    (cur_wlen)
    );

    aud_slot_tx #(
        .WORD_W (WORD_W)
    ) i_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_en     (load_en),
        .load_active (load_active),
        .load_repeat (load_repeat),
        .load_wlen   (load_wlen),
        .tx_empty    (tx_empty),
        .tx_data     (tx_data),
        .tx_pop      (tx_pop),
        .underrun    (tx_underrun),
        .sd_out      (sd_out)
    );

    aud_slot_rx #(
        .WORD_W (WORD_W),
        .BIT_W  (BIT_W)
    ) i_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .sd_in       (sd_in),
        .in_frame    (in_frame),
        .frame_start (frame_start),
        .bit_idx     (bit_idx),
        .wlen        (cur_wlen),
        .slot_end    (slot_end),
        .end_active  (end_active),
        .rx_full     (rx_full),
        .rx_push     (rx_push),
        .rx_data     (rx_data),
        .overrun     (rx_overrun)
    );

    AST_PAD_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_frame && (int'(bit_idx) >= int'(cur_wlen))) |-> !sd_out); // R5

    AST_EMPTY_MASK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_frame && ((cur_dual ? cur_mask[1:0] : cur_mask[7:0]) == '0)) |-> !sd_out); // R8

    AST_IDLE_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !in_frame |-> !sd_out); // R13

endmodule

// File: tb/test_aud_slot_serializer.sv
module test_aud_slot_serializer;

    localparam int CLK_PERIOD = 10;
    localparam int SLOT_W     = 32;
    localparam int WORD_W     = 24;
    localparam int LEN_W      = 5;
    localparam int MAXS       = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              fsync = 1'b0;
    logic              cfg_dual = 1'b0;
    logic [7:0]        cfg_mask = 8'h03;
    logic [LEN_W-1:0]  cfg_wlen = LEN_W'(24);
    logic              tx_empty;
    logic [WORD_W-1:0] tx_data;
    logic              tx_pop;
    logic              rx_full = 1'b0;
    logic              rx_push;
    logic [WORD_W-1:0] rx_data;
    logic              sd_in = 1'b0;
    logic              sd_out;
    logic              tx_underrun;
    logic              rx_overrun;

    logic [WORD_W-1:0] txq [0:15];
    int                tx_head = 0;
    int                tx_cnt  = 0;
    bit                pend_pop = 1'b0;
    bit                exp_under = 1'b0;
    bit                exp_over  = 1'b0;
    bit                after_cut = 1'b0;
    bit                done = 1'b0;
    int                n_checks = 0;
    int                n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign tx_empty = (tx_cnt == 0);
    assign tx_data  = txq[tx_head[3:0]];

    aud_slot_serializer #(
        .SLOT_W (SLOT_W),
        .WORD_W (WORD_W)
    ) i_aud_slot_serializer (
        .clk         (clk),
        .rst_n       (rst_n),
        .fsync       (fsync),
        .cfg_dual    (cfg_dual),
        .cfg_mask    (cfg_mask),
        .cfg_wlen    (cfg_wlen),
        .tx_empty    (tx_empty),
        .tx_data     (tx_data),
        .tx_pop      (tx_pop),
        .rx_full     (rx_full),
        .rx_push     (rx_push),
        .rx_data     (rx_data),
        .sd_in       (sd_in),
        .sd_out      (sd_out),
        .tx_underrun (tx_underrun),
        .rx_overrun  (rx_overrun)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int b_slots(bit dual);
        return dual ? 2 : 8;
    endfunction

    function automatic bit b_active(bit dual, logic [7:0] mask, int k);
        if (dual && k >= 2) return 1'b0;
        return mask[k];
    endfunction

    function automatic bit b_repeat(bit dual, logic [7:0] mask, int k);
        return dual && (k == 1) && (mask[1:0] == 2'b01);
    endfunction

    function automatic bit b_silent(bit dual, logic [7:0] mask);
        return dual ? (mask[1:0] == 2'b00) : (mask == 8'h00);
    endfunction

    task automatic run_frame(input bit dual, input logic [7:0] mask, input int wlen,
                             input int len, input int fill, input bit full);
        logic [WORD_W-1:0] ew [0:MAXS-1];
        logic [WORD_W-1:0] rw [0:MAXS-1];
        logic [WORD_W-1:0] lowm;
        int   ns, k, p, sl, bt;
        bit   epop, eout, epush, was_cut;
        string tg;
        ns      = b_slots(dual);
        lowm    = (WORD_W'(1) << wlen) - WORD_W'(1);
        was_cut = after_cut;
        for (int c = 0; c < len; c++) begin
            @(negedge clk);
            if (pend_pop) begin
                tx_head++;
                tx_cnt--;
                pend_pop = 1'b0;
            end
            if (c == 0) begin
                check(tx_underrun == exp_under, "R9 sticky underrun", 32'(tx_underrun), 32'(exp_under));
                check(rx_overrun == exp_over, "R10 sticky overrun", 32'(rx_overrun), 32'(exp_over));
                tx_head = 0;
                tx_cnt  = fill;
                for (int i = 0; i < 16; i++) txq[i] = WORD_W'($urandom);
                for (int i = 0; i < MAXS; i++) begin
                    ew[i] = '0;
                    rw[i] = '0;
                end
                cfg_dual = dual;
                cfg_mask = mask;
                cfg_wlen = LEN_W'(wlen);
                rx_full  = full;
                fsync    = 1'b1;
            end else begin
                fsync = 1'b0;
                if (c == 3) begin
                    cfg_dual = 1'($urandom);
                    cfg_mask = 8'($urandom);
                    cfg_wlen = LEN_W'($urandom);
                end
            end
            sd_in = 1'($urandom);
            #1;
            // fetch side
            epop = 1'b0;
            if ((c % SLOT_W) == 0 && (c / SLOT_W) < ns) begin
                k = c / SLOT_W;
                if (b_repeat(dual, mask, k)) begin
                    ew[k] = ew[0];
                end else if (b_active(dual, mask, k)) begin
                    if (tx_cnt != 0) begin
                        epop  = 1'b1;
                        ew[k] = tx_data & lowm;
                    end else begin
                        ew[k]     = '0;
                        exp_under = 1'b1;
                    end
                end
            end
            if (was_cut && c == 0) tg = "R11 pop on restart";
            else if (b_silent(dual, mask)) tg = "R8 pop";
            else if (tx_cnt == 0) tg = "R9 pop";
            else if (c > 3) tg = "R3/R12 pop";
            else tg = "R3 pop";
            check(tx_pop === epop, tg, 32'(tx_pop), 32'(epop));
            pend_pop = (tx_pop === 1'b1);
            if (c >= 1) begin
                p  = c - 1;
                sl = p / SLOT_W;
                bt = p % SLOT_W;
                eout = 1'b0;
                if (sl < ns && (b_active(dual, mask, sl) || b_repeat(dual, mask, sl)) && bt < wlen)
                    eout = ew[sl][wlen-1-bt];
                if (sl >= ns) tg = "R13 idle";
                else if (b_silent(dual, mask)) tg = "R8 silent";
                else if (b_repeat(dual, mask, sl)) tg = "R7 mono";
                else if (!b_active(dual, mask, sl)) tg = "R4 masked";
                else if (bt >= wlen) tg = "R5 pad";
                else if (was_cut && sl == 0) tg = "R11 data";
                else if (dual) tg = "R6 data";
                else tg = "R2 data";
                check(sd_out === eout, tg, 32'(sd_out), 32'(eout));
                if (sl < ns && bt < wlen) rw[sl] = {rw[sl][WORD_W-2:0], sd_in};
                epush = 1'b0;
                if (sl < ns && bt == SLOT_W - 1 && b_active(dual, mask, sl)) begin
                    if (full) exp_over = 1'b1;
                    else epush = 1'b1;
                end
                if (full) tg = "R10 push";
                else if (sl < ns && b_repeat(dual, mask, sl)) tg = "R7 push";
                else if (dual) tg = "R6 push";
                else tg = "R5 push";
                check(rx_push === epush, tg, 32'(rx_push), 32'(epush));
                if (epush && rx_push === 1'b1)
                    check(rx_data === rw[sl], "R5 rx word", 32'(rx_data), 32'(rw[sl]));
            end else begin
                check(rx_push === 1'b0, was_cut ? "R11 no push" : "R5 no push", 32'(rx_push), 32'd0);
            end
        end
        after_cut = (len < ns * SLOT_W + 1);
    endtask

    function automatic int full_len(bit dual, int gap);
        return b_slots(dual) * SLOT_W + 1 + gap;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", n_checks, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int ns, len, dual;
        logic [7:0] mask;
        void'($urandom(32'h5EED_0A1D));
        repeat (4) @(posedge clk);
        #1;
        check(sd_out === 1'b0, "R1 sd_out in reset", 32'(sd_out), 32'd0);
        check(tx_underrun === 1'b0 && rx_overrun === 1'b0, "R1 flags in reset",
              {30'd0, tx_underrun, rx_overrun}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(sd_out === 1'b0, "R1 sd_out after reset", 32'(sd_out), 32'd0);
        check(tx_pop === 1'b0 && rx_push === 1'b0, "R1 strobes after reset",
              {30'd0, tx_pop, rx_push}, 32'd0);

        // directed corner cases
        run_frame(1'b0, 8'h03, 24, full_len(1'b0, 2), 8, 1'b0);
        run_frame(1'b0, 8'hFF, 16, full_len(1'b0, 0), 9, 1'b0);
        run_frame(1'b0, 8'hA5, 8,  full_len(1'b0, 1), 8, 1'b0);
        run_frame(1'b1, 8'hFF, 20, full_len(1'b1, 3), 4, 1'b0);
        run_frame(1'b1, 8'hF1, 12, full_len(1'b1, 2), 4, 1'b0);
        run_frame(1'b1, 8'h02, 18, full_len(1'b1, 1), 4, 1'b0);
        run_frame(1'b0, 8'h00, 24, full_len(1'b0, 2), 8, 1'b0);
        run_frame(1'b1, 8'hFC, 24, full_len(1'b1, 2), 8, 1'b0);
        run_frame(1'b0, 8'hFF, 24, 3 * SLOT_W + 5, 8, 1'b0);
        run_frame(1'b0, 8'hFF, 10, full_len(1'b0, 1), 8, 1'b0);
        run_frame(1'b1, 8'h01, 24, full_len(1'b1, 1), 0, 1'b0);
        run_frame(1'b0, 8'hFF, 24, full_len(1'b0, 1), 2, 1'b0);
        run_frame(1'b0, 8'h3C, 14, full_len(1'b0, 1), 8, 1'b1);

        // constrained random frames
        for (int f = 0; f < 150; f++) begin
            dual = int'($urandom % 2);
            mask = ($urandom % 8 == 0) ? 8'h00 : 8'($urandom);
            ns   = b_slots(dual[0]);
            if ($urandom % 8 == 0) len = 2 + int'($urandom % (ns * SLOT_W - 1));
            else len = full_len(dual[0], int'($urandom % 4));
            run_frame(dual[0], mask, 8 + int'($urandom % 17), len,
                      int'($urandom % 10), ($urandom % 6) == 0);
        end

        @(negedge clk);
        if (pend_pop) begin
            tx_head++;
            tx_cnt--;
            pend_pop = 1'b0;
        end
        #1;
        check(tx_underrun == exp_under, "R9 final underrun", 32'(tx_underrun), 32'(exp_under));
        check(rx_overrun == exp_over, "R10 final overrun", 32'(rx_overrun), 32'(exp_over));
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule